// File: doc/BRIEF.md
# Bit-Addressable GPIO Port with Edge/Level Interrupts

This block is a 16-bit general-purpose I/O port behind a simple memory-mapped register bus. Software controls output drive, output enable and per-bit interrupt configuration. Output enable, interrupt enable, interrupt type and interrupt polarity are each changed through a pair of write-one-to-set and write-one-to-clear registers. Because of this, one bit never disturbs another and software never needs a read-modify-write.

Output data can be written as a whole word. It can also be written through two masked windows, one per byte, in which the bit mask is carried in the address. A single store then changes only the selected bits. The input path passes every pin through a two-flop synchronizer, and the synchronized value is always readable, even for pins the port is driving. Each bit detects either one edge (rising or falling) or one level (high or low), never both edges. To catch both edges, route one pin to two bits and configure each bit for one edge.

Pending bits are latched per pin, read from a status register and cleared by writing ones to it. The port drives one combined interrupt line.

Top module: `gpio_port`

## Requirements
- R1: After reset the output data, output enable, interrupt enable, type, polarity and pending registers are all zero, and `irq` is low.
- R2: For output enable (set 0x010, clear 0x014), interrupt enable (set 0x018, clear 0x01C), type (set 0x020, clear 0x024) and polarity (set 0x028, clear 0x02C), a write sets or clears exactly the bits written as 1. Bits written as 0 keep their value. Reading either address returns the current register, and `pin_oe` equals the output enable register.
- R3: A write to 0x004 replaces the whole output data register, which drives `pin_out` and reads back at 0x004. Without a bus write, `pin_out` holds its value.
- R4: A write to 0x400 + 4*m (m = 0..255) loads only those bits of `pin_out[7:0]` that are set in m, taking them from `bus_wdata[7:0]`. All other output bits are unchanged.
- R5: A write to 0x800 + 4*m (m = 0..255) loads only those bits of `pin_out[15:8]` whose bit (i-8) is set in m, taking them from `bus_wdata[15:8]`. All other output bits are unchanged.
- R6: Reading 0x000 returns the pin state after a two-flop synchronizer, so a change is visible after the second rising clock edge. This holds whether or not the pin is being driven.
- R7: With type bit 1 (edge), polarity 1 latches pending on a rising edge only, and polarity 0 latches pending on a falling edge only.
- R8: With type bit 0 (level), polarity 1 keeps pending set while the pin is high, and polarity 0 keeps it set while the pin is low. A clear written while the level persists has no lasting effect. After the level is removed, a clear succeeds.
- R9: Reading 0x038 returns the pending bits. Writing 1s there clears those bits, and 0s leave bits unchanged. When a new event and a clear fall in the same cycle, the event wins.
- R10: Pending latches only for enabled bits. `irq` is high exactly when some bit is both pending and enabled. Clearing an enable bit drops its contribution to `irq` but leaves its pending bit intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| pin_in | input | 16 | Pin levels from the pads |
| pin_out | output | 16 | Output data to the pads |
| pin_oe | output | 16 | Output enable per pin |
| irq | output | 1 | Combined interrupt |

## Verification
Several properties are checked on every cycle: the set/clear registers act on enable bits, each masked window leaves the other byte untouched, `pin_out` holds between writes, `irq` needs a set enable bit, and pending survives an enable clear. Other behaviours only show up in the bench's scenarios: synchronizer latency, edge direction selection, a level that re-asserts pending against a clear, masking of events on disabled bits, and random masked updates compared with a reference model.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int PORT_W = 16;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 12;
    localparam int NUM_CFG = 4;

    localparam logic [ADDR_W-1:0] A_DIN    = 12'h000;
    localparam logic [ADDR_W-1:0] A_DOUT   = 12'h004;
    localparam logic [ADDR_W-1:0] A_OE_SET = 12'h010;
    localparam logic [ADDR_W-1:0] A_OE_CLR = 12'h014;
    localparam logic [ADDR_W-1:0] A_IE_SET = 12'h018;
    localparam logic [ADDR_W-1:0] A_IE_CLR = 12'h01C;
    localparam logic [ADDR_W-1:0] A_TY_SET = 12'h020;
    localparam logic [ADDR_W-1:0] A_TY_CLR = 12'h024;
    localparam logic [ADDR_W-1:0] A_PO_SET = 12'h028;
    localparam logic [ADDR_W-1:0] A_PO_CLR = 12'h02C;
    localparam logic [ADDR_W-1:0] A_STAT   = 12'h038;
    localparam logic [1:0] WIN_LO = 2'b01;
    localparam logic [1:0] WIN_HI = 2'b10;

    // configuration register index
    localparam int CFG_OE = 0;
    localparam int CFG_IE = 1;
    localparam int CFG_TY = 2;
    localparam int CFG_PO = 3;

    typedef enum logic [2:0] {
        OP_NONE, OP_DIN, OP_DOUT, OP_WIN_LO, OP_WIN_HI, OP_SET, OP_CLR, OP_STAT
    } op_e;

    typedef struct packed {
        op_e         op;
        logic [1:0]  sel;
        logic [BYTE_W-1:0] mask;
    } dec_t;

    typedef struct packed {
        logic [PORT_W-1:0] oe;
        logic [PORT_W-1:0] ie;
        logic [PORT_W-1:0] typ;
        logic [PORT_W-1:0] pol;
    } cfg_t;

    function automatic dec_t decode(input logic [ADDR_W-1:0] a);
        dec_t d;
        d.op   = OP_NONE;
        d.sel  = 2'd0;
        d.mask = a[9:2];
        if (a[11:10] == WIN_LO && a[1:0] == 2'b00) begin
            d.op = OP_WIN_LO;
        end else if (a[11:10] == WIN_HI && a[1:0] == 2'b00) begin
            d.op = OP_WIN_HI;
        end else begin
            case (a)
                A_DIN:    d.op = OP_DIN;
                A_DOUT:   d.op = OP_DOUT;
                A_STAT:   d.op = OP_STAT;
                A_OE_SET, A_IE_SET, A_TY_SET, A_PO_SET: begin
                    d.op  = OP_SET;
                    d.sel = a[4:3] - 2'd2;
                end
                A_OE_CLR, A_IE_CLR, A_TY_CLR, A_PO_CLR: begin
                    d.op  = OP_CLR;
                    d.sel = a[4:3] - 2'd2;
                end
                default:  d.op = OP_NONE;
            endcase
        end
        return d;
    endfunction

    function automatic logic [PORT_W-1:0] merge_bits(
        input logic [PORT_W-1:0] old_v,
        input logic [PORT_W-1:0] new_v,
        input logic [PORT_W-1:0] sel);
        return (old_v & ~sel) | (new_v & sel);
    endfunction

    function automatic logic bit_event(input logic typ, input logic pol,
                                       input logic cur, input logic prev);
        logic ev;
        if (typ)
            ev = pol ? (cur & ~prev) : (~cur & prev);
        else
            ev = pol ? cur : ~cur;
        return ev;
    endfunction
endpackage

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs
    import gpio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  dec_t              dec,
    input  logic [PORT_W-1:0] wdata,
    output cfg_t              cfg,
    output logic [PORT_W-1:0] dout
);
    logic [NUM_CFG-1:0][PORT_W-1:0] cfg_q;
    logic [PORT_W-1:0] win_sel;

    for (genvar k = 0; k < NUM_CFG; k++) begin : g_cfg
        always_ff @(posedge clk) begin
            if (rst)
                cfg_q[k] <= '0;
            else if (wr && dec.sel == 2'(k) && dec.op == OP_SET)
                cfg_q[k] <= cfg_q[k] | wdata;
            else if (wr && dec.sel == 2'(k) && dec.op == OP_CLR)
                cfg_q[k] <= cfg_q[k] & ~wdata;
        end
    end

    always_comb begin
        case (dec.op)
            OP_WIN_LO: win_sel = {{BYTE_W{1'b0}}, dec.mask};
            OP_WIN_HI: win_sel = {dec.mask, {BYTE_W{1'b0}}};
            OP_DOUT:   win_sel = '1;
            default:   win_sel = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            dout <= '0;
        else if (wr)
            dout <= merge_bits(dout, wdata, win_sel);
    end

    assign cfg.oe  = cfg_q[CFG_OE];
    assign cfg.ie  = cfg_q[CFG_IE];
    assign cfg.typ = cfg_q[CFG_TY];
    assign cfg.pol = cfg_q[CFG_PO];
endmodule

// File: rtl/gpio_sync_edge.sv
module gpio_sync_edge #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] synced,
    output logic [W-1:0] prev
);
    logic [STAGES-1:0][W-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst)
            chain[0] <= '0;
        else
            chain[0] <= pin_in;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst)
                chain[s] <= '0;
            else
                chain[s] <= chain[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            prev <= '0;
        else
            prev <= chain[STAGES-1];
    end

    assign synced = chain[STAGES-1];
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [PORT_W-1:0] synced,
    input  logic [PORT_W-1:0] prev,
    input  logic [PORT_W-1:0] typ,
    input  logic [PORT_W-1:0] pol,
    input  logic [PORT_W-1:0] ie,
    input  logic              clr_we,
    input  logic [PORT_W-1:0] clr_bits,
    output logic [PORT_W-1:0] pend,
    output logic              irq
);
    logic [PORT_W-1:0] ev;

    for (genvar i = 0; i < PORT_W; i++) begin : g_bit
        assign ev[i] = ie[i] & bit_event(typ[i], pol[i], synced[i], prev[i]);

        always_ff @(posedge clk) begin
            if (rst)
                pend[i] <= 1'b0;
            else if (ev[i])
                pend[i] <= 1'b1;
            else if (clr_we && clr_bits[i])
                pend[i] <= 1'b0;
        end
    end

    assign irq = |(pend & ie);
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_wr,
    input  logic [11:0] bus_addr,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    input  logic [15:0] pin_in,
    output logic [15:0] pin_out,
    output logic [15:0] pin_oe,
    output logic        irq
);
    dec_t              dec;
    cfg_t              cfg;
    logic [PORT_W-1:0] dout_q;
    logic [PORT_W-1:0] synced;
    logic [PORT_W-1:0] prev;
    logic [PORT_W-1:0] pend_q;
    logic [PORT_W-1:0] ie_q;
    logic [NUM_CFG-1:0][PORT_W-1:0] cfg_view;

    assign dec = decode(bus_addr);

    gpio_ctrl_regs i_regs (
        .clk   (clk),
        .rst   (rst),
        .wr    (bus_wr),
        .dec   (dec),
        .wdata (bus_wdata),
        .cfg   (cfg),
        .dout  (dout_q)
    );

    gpio_sync_edge #(.W(PORT_W), .STAGES(SYNC_STAGES)) i_sync (
        .clk    (clk),
        .rst    (rst),
        .pin_in (pin_in),
        .synced (synced),
        .prev   (prev)
    );

    gpio_irq_ctrl i_irq (
        .clk      (clk),
        .rst      (rst),
        .synced   (synced),
        .prev     (prev),
        .typ      (cfg.typ),
        .pol      (cfg.pol),
        .ie       (cfg.ie),
        .clr_we   (bus_wr && dec.op == OP_STAT),
        .clr_bits (bus_wdata),
        .pend     (pend_q),
        .irq      (irq)
    );

    assign ie_q = cfg.ie;
    assign cfg_view[CFG_OE] = cfg.oe;
    assign cfg_view[CFG_IE] = cfg.ie;
    assign cfg_view[CFG_TY] = cfg.typ;
    assign cfg_view[CFG_PO] = cfg.pol;

    always_comb begin
        case (dec.op)
            OP_DIN:         bus_rdata = synced;
            OP_DOUT:        bus_rdata = dout_q;
            OP_WIN_LO:      bus_rdata = dout_q & {{BYTE_W{1'b0}}, dec.mask};
            OP_WIN_HI:      bus_rdata = dout_q & {dec.mask, {BYTE_W{1'b0}}};
            OP_SET, OP_CLR: bus_rdata = cfg_view[dec.sel];
            OP_STAT:        bus_rdata = pend_q;
            default:        bus_rdata = '0;
        endcase
    end

    assign pin_out = dout_q;
    assign pin_oe  = cfg.oe;
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
    import gpio_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        bus_wr,
    input logic [11:0] bus_addr,
    input logic [15:0] bus_wdata,
    input logic [15:0] pin_out,
    input logic [15:0] pin_oe,
    input logic        irq,
    input logic [15:0] ie,
    input logic [15:0] pend
);
    // R1: reset clears outputs
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (pin_out == '0 && pin_oe == '0 && !irq));

    // R2: set register sets written ones
    a_r2_oe_set: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == A_OE_SET) |=> ((pin_oe & $past(bus_wdata)) == $past(bus_wdata)));

    // R2: clear register clears written ones
    a_r2_oe_clr: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == A_OE_CLR) |=> ((pin_oe & $past(bus_wdata)) == '0));

    // R3: output holds without a write
    a_r3_out_hold: assert property (@(posedge clk) disable iff (rst)
        !bus_wr |=> $stable(pin_out));

    // R4: low window leaves upper byte alone
    a_r4_low_window: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr[11:10] == WIN_LO) |=> (pin_out[15:8] == $past(pin_out[15:8])));

    // R5: high window leaves lower byte alone
    a_r5_high_window: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr[11:10] == WIN_HI) |=> (pin_out[7:0] == $past(pin_out[7:0])));

    // R10: interrupt needs an enabled bit
    a_r10_irq_enabled: assert property (@(posedge clk) disable iff (rst)
        irq |-> (ie != '0));

    // R10: clearing enables keeps pending bits
    a_r10_mask_keeps_pend: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == A_IE_CLR) |=> ((pend & $past(pend)) == $past(pend)));
endmodule

bind gpio_port gpio_port_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .irq       (irq),
    .ie        (ie_q),
    .pend      (pend_q)
);

// File: tb/test_gpio_port.sv
module test_gpio_port;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [15:0] pin_in = '0;
    logic [15:0] pin_out;
    logic [15:0] pin_oe;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [15:0] model_out = '0;

    always #4 clk = ~clk;

    gpio_port i_gpio_port (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    function automatic logic [15:0] win_lo(input logic [15:0] o, input logic [7:0] m,
                                           input logic [15:0] d);
        logic [15:0] s = {8'h00, m};
        return (o & ~s) | (d & s);
    endfunction

    function automatic logic [15:0] win_hi(input logic [15:0] o, input logic [7:0] m,
                                           input logic [15:0] d);
        logic [15:0] s = {m, 8'h00};
        return (o & ~s) | (d & s);
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
        bus_addr = '0;
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] v;
        void'($urandom(32'd20240611));
        cycles(3);
        rst = 1'b0;
        cycles(1);

        // R1: reset state
        check("R1 pin_out", pin_out, 16'h0000);
        check("R1 pin_oe", pin_oe, 16'h0000);
        check("R1 irq", {15'd0, irq}, 16'h0000);
        rd(12'h038, v); check("R1 pending", v, 16'h0000);
        rd(12'h020, v); check("R1 type", v, 16'h0000);

        // R2: set/clear pairs
        wr(12'h010, 16'hA5F0);
        check("R2 oe set", pin_oe, 16'hA5F0);
        wr(12'h010, 16'h0000);
        check("R2 oe set zero no effect", pin_oe, 16'hA5F0);
        wr(12'h014, 16'h0030);
        check("R2 oe clr", pin_oe, 16'hA5C0);
        rd(12'h014, v); check("R2 oe read at clr", v, 16'hA5C0);
        wr(12'h028, 16'h0F0F);
        wr(12'h02C, 16'h0003);
        rd(12'h028, v); check("R2 polarity", v, 16'h0F0C);
        wr(12'h02C, 16'hFFFF);

        // R3: full word write
        wr(12'h004, 16'h1234);
        model_out = 16'h1234;
        check("R3 pin_out", pin_out, 16'h1234);
        rd(12'h004, v); check("R3 readback", v, 16'h1234);
        cycles(3);
        check("R3 hold", pin_out, 16'h1234);

        // R4/R5: directed window corners
        wr(12'h400 + 12'(4 * 8'h81), 16'hFFFF);
        model_out = win_lo(model_out, 8'h81, 16'hFFFF);
        check("R4 low window mask 81", pin_out, model_out);
        wr(12'h400, 16'h0000);
        check("R4 low window mask 00", pin_out, model_out);
        wr(12'h800 + 12'(4 * 8'hF0), 16'h0000);
        model_out = win_hi(model_out, 8'hF0, 16'h0000);
        check("R5 high window mask F0", pin_out, model_out);
        wr(12'h800 + 12'(4 * 8'hFF), 16'hBEEF);
        model_out = win_hi(model_out, 8'hFF, 16'hBEEF);
        check("R5 high window mask FF", pin_out, model_out);

        // R3/R4/R5: random mix of writes
        for (int n = 0; n < 200; n++) begin
            int kind = int'($urandom_range(2, 0));
            logic [7:0] m = 8'($urandom);
            logic [15:0] d = 16'($urandom);
            if (kind == 0) begin
                wr(12'h400 + 12'(4 * m), d);
                model_out = win_lo(model_out, m, d);
                check("R4 random low window", pin_out, model_out);
            end else if (kind == 1) begin
                wr(12'h800 + 12'(4 * m), d);
                model_out = win_hi(model_out, m, d);
                check("R5 random high window", pin_out, model_out);
            end else begin
                wr(12'h004, d);
                model_out = d;
                check("R3 random word", pin_out, model_out);
            end
        end

        // R6: synchronizer latency, visible while driven
        @(negedge clk);
        pin_in = 16'h00C3;
        @(negedge clk);
        rd(12'h000, v); check("R6 din after one edge", v, 16'h0000);
        @(negedge clk);
        rd(12'h000, v); check("R6 din after two edges", v, 16'h00C3);
        check("R6 read with oe set", {15'd0, pin_oe[7]}, 16'h0001);
        pin_in = 16'h0000;
        cycles(4);

        // R7: rising edge on bit 0, falling edge on bit 1
        wr(12'h020, 16'h0003);
        wr(12'h028, 16'h0001);
        wr(12'h018, 16'h0003);
        @(negedge clk); pin_in = 16'h0003;
        cycles(4);
        rd(12'h038, v); check("R7 rising only bit0", v, 16'h0001);
        check("R10 irq with pending", {15'd0, irq}, 16'h0001);
        wr(12'h038, 16'h0001);
        rd(12'h038, v); check("R9 write one clears", v, 16'h0000);
        pin_in = 16'h0000;
        cycles(4);
        rd(12'h038, v); check("R7 falling only bit1", v, 16'h0002);
        wr(12'h038, 16'h0000);
        rd(12'h038, v); check("R9 write zero keeps", v, 16'h0002);

        // R10: disable masks irq, keeps pending
        wr(12'h01C, 16'h0002);
        check("R10 irq masked", {15'd0, irq}, 16'h0000);
        rd(12'h038, v); check("R10 pending kept", v, 16'h0002);
        wr(12'h038, 16'hFFFF);
        // events on disabled bit 1 do not latch
        @(negedge clk); pin_in = 16'h0002;
        cycles(2);
        pin_in = 16'h0000;
        cycles(4);
        rd(12'h038, v); check("R10 disabled no latch", v, 16'h0000);

        // R8: level high on bit 4
        wr(12'h028, 16'h0010);
        wr(12'h018, 16'h0010);
        @(negedge clk); pin_in = 16'h0010;
        cycles(4);
        rd(12'h038, v); check("R8 level pending", v, 16'h0010);
        wr(12'h038, 16'h0010);
        rd(12'h038, v); check("R8 clear while level held", v, 16'h0010);
        pin_in = 16'h0000;
        cycles(4);
        wr(12'h038, 16'h0010);
        rd(12'h038, v); check("R8 clear after level gone", v, 16'h0000);
        check("R8 irq low", {15'd0, irq}, 16'h0000);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule